// File: doc/BRIEF.md
# Dual-Priority Interrupt Vector Unit

This block is the exception-entry decision point of a small RISC core. Two request lines, a normal one and a fast one, each gated by its own enable, are looked at only on cycles the core marks as instruction boundaries. When a request wins, the unit pulses a one-cycle take strobe. It also presents the byte address of the 32-bit handler pointer to fetch from a 128-entry vector table. The base of that table is relocatable and is held in a register that can be written.

A requesting device may supply its own vector number. When it does not, the unit substitutes a fixed autovector, and the normal and fast autovectors differ. The unit also tracks which handlers are open. From that it tells the core which register context to use: the main set, the alternate set for a normal handler, or the dedicated shadow set for a fast handler. A fast request may interrupt a normal handler. Nothing interrupts a fast handler. The core signals the end of a handler with an exit pulse, which closes the innermost open handler.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, take is 0, ctx_sel is 2'b00, vec_addr is 0, and the table base equals the RESET_BASE parameter.
- R2: A request is considered only at a rising clock edge where insn_boundary is 1. A win raises take for exactly the following cycle, and take is 0 otherwise.
- R3: When both requests are eligible at the same boundary, the fast request is taken.
- R4: A request whose enable is 0 is never taken.
- R5: On a take, vec_addr equals the table base plus four times the selected vector number. A base write stores base_wdata with bits [8:0] forced to zero.
- R6: The selected vector is the device-supplied number when the winner's vector-valid input is 1. Otherwise it is the autovector, which is 16 for normal and 17 for fast with the default parameters.
- R7: ctx_sel encodes the active context: 2'b10 while a fast handler is open, else 2'b01 while a normal handler is open, else 2'b00. vec_addr holds its last taken value between takes.
- R8: No normal request is taken while a fast handler is open. A fast request is taken while a normal handler is open, and leaves the normal handler pending underneath.
- R9: A request of a level whose handler is already open is not taken again.
- R10: An hnd_exit pulse closes the fast handler if one is open, otherwise the normal one. No request is taken at an edge where hnd_exit is 1.
- R11: A take at the same edge as a base write uses the base held before that write. Later takes use the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_wr | input | 1 | Write strobe for the table base register |
| base_wdata | input | ADDR_W | New table base; low 9 bits discarded |
| insn_boundary | input | 1 | Current cycle is an instruction boundary |
| hnd_exit | input | 1 | Innermost open handler finishes |
| nrm_req | input | 1 | Normal interrupt request |
| nrm_en | input | 1 | Normal interrupt enable |
| nrm_vec_vld | input | 1 | Normal requester supplies a vector number |
| nrm_vec | input | VEC_W | Vector number from the normal requester |
| fst_req | input | 1 | Fast interrupt request |
| fst_en | input | 1 | Fast interrupt enable |
| fst_vec_vld | input | 1 | Fast requester supplies a vector number |
| fst_vec | input | VEC_W | Vector number from the fast requester |
| take | output | 1 | One-cycle exception entry strobe |
| vec_addr | output | ADDR_W | Byte address of the handler pointer |
| ctx_sel | output | 2 | Register context: 00 main, 01 alternate, 10 fast shadow |

## Verification
The bench builds the unit with its defaults: a 32-bit address, a 7-bit vector number, autovectors 16 and 17, a reset base of 0x400, the OR-based address combine and fast preemption enabled. The nonzero reset base together with writes of arbitrary base values exercises the masking of the low nine bits, and checks that a write landing on a take edge does not leak into that take. With preemption enabled, nested fast-over-normal handlers become reachable. Long random runs therefore reach exit ordering, blocked normal requests under a fast handler, and repeated requests at an already open level.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
   typedef enum logic [1:0] {
      CTX_MAIN = 2'b00,
      CTX_ALT  = 2'b01,
      CTX_FAST = 2'b10
   } ctx_e;

   typedef enum logic [1:0] {
      WIN_NONE = 2'b00,
      WIN_NRM  = 2'b01,
      WIN_FST  = 2'b10
   } win_e;
endpackage

// File: rtl/ivu_arbiter.sv
module ivu_arbiter
   import ivu_pkg::*;
#(
   parameter bit FAST_PREEMPT = 1'b1
) (
   input  logic boundary,
   input  logic exit_req,
   input  logic nrm_req,
   input  logic nrm_en,
   input  logic fst_req,
   input  logic fst_en,
   input  logic nrm_busy,
   input  logic fst_busy,
   output win_e win
);
   logic open_slot;
   logic fst_ok;
   logic nrm_ok;

   assign open_slot = boundary && !exit_req;

   generate
      if (FAST_PREEMPT) begin : g_preempt
         assign fst_ok = !fst_busy;
      end else begin : g_no_preempt
         assign fst_ok = !fst_busy && !nrm_busy;
      end
   endgenerate

   assign nrm_ok = !fst_busy && !nrm_busy;

   always_comb begin
      win = WIN_NONE;
      if (open_slot) begin
         if (fst_req && fst_en && fst_ok)
            win = WIN_FST;
         else if (nrm_req && nrm_en && nrm_ok)
            win = WIN_NRM;
      end
   end
endmodule

// File: rtl/ivu_vec_gen.sv
module ivu_vec_gen
   import ivu_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned VEC_W     = 7,
   parameter int unsigned NRM_AUTO  = 16,
   parameter int unsigned FST_AUTO  = 17,
   parameter bit          ADD_STYLE = 1'b0
) (
   input  win_e              win,
   input  logic              nrm_vld,
   input  logic [VEC_W-1:0]  nrm_vec,
   input  logic              fst_vld,
   input  logic [VEC_W-1:0]  fst_vec,
   input  logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] addr
);
   localparam int unsigned OFS_W = VEC_W + 2;
   localparam logic [VEC_W-1:0] NRM_AV = VEC_W'(NRM_AUTO);
   localparam logic [VEC_W-1:0] FST_AV = VEC_W'(FST_AUTO);

   logic [VEC_W-1:0]  sel_vec;
   logic [ADDR_W-1:0] offset;

   always_comb begin
      case (win)
         WIN_FST: sel_vec = fst_vld ? fst_vec : FST_AV;
         WIN_NRM: sel_vec = nrm_vld ? nrm_vec : NRM_AV;
         default: sel_vec = '0;
      endcase
   end

   assign offset = {{(ADDR_W-OFS_W){1'b0}}, sel_vec, 2'b00};

   generate
      if (ADD_STYLE) begin : g_adder
         assign addr = base + offset;
      end else begin : g_merge
         assign addr = base | offset;
      end
   endgenerate
endmodule

// File: rtl/ivu_ctx_track.sv
module ivu_ctx_track
   import ivu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  win_e win,
   input  logic exit_req,
   output logic nrm_busy,
   output logic fst_busy,
   output ctx_e ctx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nrm_busy <= 1'b0;
         fst_busy <= 1'b0;
      end else begin
         if (exit_req) begin
            if (fst_busy)
               fst_busy <= 1'b0;
            else
               nrm_busy <= 1'b0;
         end
         if (win == WIN_FST)
            fst_busy <= 1'b1;
         else if (win == WIN_NRM)
            nrm_busy <= 1'b1;
      end
   end

   always_comb begin
      if (fst_busy)
         ctx = CTX_FAST;
      else if (nrm_busy)
         ctx = CTX_ALT;
      else
         ctx = CTX_MAIN;
   end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
   import ivu_pkg::*;
#(
   parameter int unsigned          ADDR_W       = 32,
   parameter int unsigned          VEC_W        = 7,
   parameter int unsigned          NRM_AUTO     = 16,
   parameter int unsigned          FST_AUTO     = 17,
   parameter logic [ADDR_W-1:0]    RESET_BASE   = 32'h0000_0400,
   parameter bit                   ADD_STYLE    = 1'b0,
   parameter bit                   FAST_PREEMPT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_wr,
   input  logic [ADDR_W-1:0] base_wdata,
   input  logic              insn_boundary,
   input  logic              hnd_exit,
   input  logic              nrm_req,
   input  logic              nrm_en,
   input  logic              nrm_vec_vld,
   input  logic [VEC_W-1:0]  nrm_vec,
   input  logic              fst_req,
   input  logic              fst_en,
   input  logic              fst_vec_vld,
   input  logic [VEC_W-1:0]  fst_vec,
   output logic              take,
   output logic [ADDR_W-1:0] vec_addr,
   output logic [1:0]        ctx_sel
);
   localparam int unsigned NUM_VEC = 1 << VEC_W;
   localparam int unsigned ALIGN   = VEC_W + 2;
   localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-ALIGN){1'b1}}, {ALIGN{1'b0}}};

   initial begin
      assert (ADDR_W > ALIGN)
         else $error("ADDR_W must exceed the table span width");
      assert (NRM_AUTO < NUM_VEC && FST_AUTO < NUM_VEC)
         else $error("autovector outside the table");
      assert (NRM_AUTO != FST_AUTO)
         else $error("autovectors must differ");
      assert ((RESET_BASE & ~ALIGN_MASK) == '0)
         else $error("RESET_BASE not aligned to the table span");
   end

   win_e              win;
   logic              nrm_busy;
   logic              fst_busy;
   ctx_e              ctx;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] next_addr;

   ivu_arbiter #(.FAST_PREEMPT(FAST_PREEMPT)) u_arb (
      .boundary (insn_boundary),
      .exit_req (hnd_exit),
      .nrm_req  (nrm_req),
      .nrm_en   (nrm_en),
      .fst_req  (fst_req),
      .fst_en   (fst_en),
      .nrm_busy (nrm_busy),
      .fst_busy (fst_busy),
      .win      (win)
   );

   ivu_vec_gen #(
      .ADDR_W    (ADDR_W),
      .VEC_W     (VEC_W),
      .NRM_AUTO  (NRM_AUTO),
      .FST_AUTO  (FST_AUTO),
      .ADD_STYLE (ADD_STYLE)
   ) u_vec (
      .win     (win),
      .nrm_vld (nrm_vec_vld),
      .nrm_vec (nrm_vec),
      .fst_vld (fst_vec_vld),
      .fst_vec (fst_vec),
      .base    (base_q),
      .addr    (next_addr)
   );

   ivu_ctx_track u_ctx (
      .clk      (clk),
      .rst_n    (rst_n),
      .win      (win),
      .exit_req (hnd_exit),
      .nrm_busy (nrm_busy),
      .fst_busy (fst_busy),
      .ctx      (ctx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= RESET_BASE;
         take     <= 1'b0;
         vec_addr <= '0;
      end else begin
         if (base_wr)
            base_q <= base_wdata & ALIGN_MASK;
         take <= (win != WIN_NONE);
         if (win != WIN_NONE)
            vec_addr <= next_addr;
      end
   end

   assign ctx_sel = ctx;
endmodule

// File: rtl/ivu_chk.sv
module ivu_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              insn_boundary,
   input logic              hnd_exit,
   input logic              nrm_req,
   input logic              nrm_en,
   input logic              fst_req,
   input logic              fst_en,
   input logic              take,
   input logic [ADDR_W-1:0] vec_addr,
   input logic [1:0]        ctx_sel
);
   // R2
   take_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_boundary |=> !take);

   // R3
   fast_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_boundary && !hnd_exit && fst_req && fst_en && ctx_sel != 2'b10)
      |=> (take && ctx_sel == 2'b10));

   // R4
   gate_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(fst_req && fst_en) && !(nrm_req && nrm_en)) |=> !take);

   // R5
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> vec_addr[1:0] == 2'b00);

   // R7
   ctx_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ctx_sel != 2'b00);

   // R8
   fast_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_sel == 2'b10 && !hnd_exit) |=> ctx_sel == 2'b10);

   // R10
   exit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hnd_exit |=> !take);
endmodule

bind irq_vector_unit ivu_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .insn_boundary (insn_boundary),
   .hnd_exit      (hnd_exit),
   .nrm_req       (nrm_req),
   .nrm_en        (nrm_en),
   .fst_req       (fst_req),
   .fst_en        (fst_en),
   .take          (take),
   .vec_addr      (vec_addr),
   .ctx_sel       (ctx_sel)
);

// File: tb/irq_vector_unit_test.sv
module irq_vector_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_wr = 1'b0;
   logic [31:0] base_wdata = '0;
   logic        insn_boundary = 1'b0;
   logic        hnd_exit = 1'b0;
   logic        nrm_req = 1'b0, nrm_en = 1'b0, nrm_vec_vld = 1'b0;
   logic [6:0]  nrm_vec = '0;
   logic        fst_req = 1'b0, fst_en = 1'b0, fst_vec_vld = 1'b0;
   logic [6:0]  fst_vec = '0;
   logic        take;
   logic [31:0] vec_addr;
   logic [1:0]  ctx_sel;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [31:0] m_base = 32'h0000_0400;
   logic [31:0] m_addr = '0;
   bit          m_n = 1'b0;
   bit          m_f = 1'b0;

   always #4 clk = ~clk;

   irq_vector_unit uut (
      .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
      .insn_boundary(insn_boundary), .hnd_exit(hnd_exit),
      .nrm_req(nrm_req), .nrm_en(nrm_en), .nrm_vec_vld(nrm_vec_vld), .nrm_vec(nrm_vec),
      .fst_req(fst_req), .fst_en(fst_en), .fst_vec_vld(fst_vec_vld), .fst_vec(fst_vec),
      .take(take), .vec_addr(vec_addr), .ctx_sel(ctx_sel)
   );

   function automatic logic [31:0] tbl_addr(logic [31:0] b, logic [6:0] v);
      return b + {23'd0, v, 2'b00};
   endfunction

   function automatic logic [1:0] exp_ctx();
      return m_f ? 2'b10 : (m_n ? 2'b01 : 2'b00);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      base_wr = 0; insn_boundary = 0; hnd_exit = 0;
      nrm_req = 0; nrm_en = 0; nrm_vec_vld = 0;
      fst_req = 0; fst_en = 0; fst_vec_vld = 0;
   endtask

   // one clock: predict from driven inputs, advance, compare at negedge
   task automatic cyc(string req);
      bit ef, en, etake;
      ef = insn_boundary && !hnd_exit && fst_req && fst_en && !m_f;
      en = insn_boundary && !hnd_exit && nrm_req && nrm_en && !m_f && !m_n;
      etake = ef || en;
      if (hnd_exit) begin
         if (m_f) m_f = 0; else m_n = 0;
      end
      if (ef) begin
         m_f = 1;
         m_addr = tbl_addr(m_base, fst_vec_vld ? fst_vec : 7'd17);
      end else if (en) begin
         m_n = 1;
         m_addr = tbl_addr(m_base, nrm_vec_vld ? nrm_vec : 7'd16);
      end
      if (base_wr) m_base = base_wdata & 32'hFFFF_FE00;
      @(posedge clk);
      @(negedge clk);
      check({req, " take"}, {31'd0, take}, {31'd0, etake});
      check({req, " ctx"}, {30'd0, ctx_sel}, {30'd0, exp_ctx()});
      check({req, " addr"}, vec_addr, m_addr);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL R2 watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7391));
      idle();
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 take", {31'd0, take}, 32'd0);
      check("R1 ctx", {30'd0, ctx_sel}, 32'd0);
      check("R1 addr", vec_addr, 32'd0);
      rst_n = 1;
      idle(); cyc("R1");

      // R6 normal autovector from reset base 0x400
      nrm_req = 1; nrm_en = 1; insn_boundary = 1; cyc("R6");
      // R9 normal held again while normal open
      cyc("R9");
      // R8 fast with device vector 5 preempts normal
      fst_req = 1; fst_en = 1; fst_vec_vld = 1; fst_vec = 7'd5; cyc("R8");
      // R8 normal blocked under fast; R9 fast not re-taken
      cyc("R8");
      // R10 exit closes fast first, request blocked on exit edge
      idle(); hnd_exit = 1; nrm_req = 1; nrm_en = 1; insn_boundary = 1; cyc("R10");
      idle(); hnd_exit = 1; cyc("R10");
      // R3 both at once, fast autovector
      idle(); nrm_req = 1; nrm_en = 1; fst_req = 1; fst_en = 1; insn_boundary = 1; cyc("R3");
      idle(); hnd_exit = 1; cyc("R10");
      // R2 no boundary, nothing taken
      idle(); nrm_req = 1; nrm_en = 1; fst_req = 1; fst_en = 1; cyc("R2");
      // R4 enables low
      idle(); nrm_req = 1; fst_req = 1; insn_boundary = 1; cyc("R4");
      // R6 normal with device vector 127
      idle(); nrm_req = 1; nrm_en = 1; nrm_vec_vld = 1; nrm_vec = 7'd127; insn_boundary = 1;
      cyc("R6");
      idle(); hnd_exit = 1; cyc("R10");
      // R11 base write on a take edge uses old base
      idle(); base_wr = 1; base_wdata = 32'h1234_5FFF; nrm_req = 1; nrm_en = 1;
      insn_boundary = 1; cyc("R11");
      idle(); hnd_exit = 1; cyc("R10");
      // R5 new base with masked low bits
      idle(); fst_req = 1; fst_en = 1; insn_boundary = 1; cyc("R5");
      idle(); hnd_exit = 1; cyc("R10");
      idle(); cyc("R7");

      // random phase
      for (int i = 0; i < 6000; i++) begin
         base_wr       = ($urandom % 40) == 0;
         base_wdata    = $urandom;
         insn_boundary = ($urandom % 4) != 0;
         hnd_exit      = ($urandom % 6) == 0;
         nrm_req       = ($urandom % 2) == 0;
         nrm_en        = ($urandom % 4) != 0;
         nrm_vec_vld   = ($urandom % 2) == 0;
         nrm_vec       = 7'($urandom);
         fst_req       = ($urandom % 3) == 0;
         fst_en        = ($urandom % 4) != 0;
         fst_vec_vld   = ($urandom % 2) == 0;
         fst_vec       = 7'($urandom);
         cyc("R5/R7 random");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule